// File: doc/BRIEF.md
# Register-width access adapter

This block sits between a processor-side port and a register file whose registers do not all share one width. The processor side may issue byte, halfword or word accesses to any register. The register side only accepts an access whose size equals the register's own width. The adapter looks up each register's native width in a per-slot table. It then rewrites the request into one or more register-side accesses: a pass-through, a read-modify-write for a narrow write, a lane extraction for a narrow read, or a sequence of ascending beats for a wide access.

Byte lanes are big-endian. The byte at the lowest address is always the most significant part of a value. Data on both ports is right-justified, so a byte sits in bits [7:0] and a halfword in bits [15:0].

The processor-side request is held, with `up_valid` high, until `up_ready` pulses for one cycle. The register side handles one access at a time with a valid/ready handshake.

Top module: `regwidth_adapter`

## Requirements
- R1: The register window spans offsets 0x000 to 0x1FF, and each 4-byte slot takes its native width from a table indexed by address bits [8:2]. The default layout is: 0x000-0x03F byte, 0x040-0x09F halfword, 0x0A0-0x0FF word, 0x100-0x17F byte, 0x180-0x1BF halfword, 0x1C0-0x1FF unmapped. Every register-side access uses its slot's native size (dn_size 0 = byte, 1 = halfword, 2 = word) and stays inside the slot of the request.
- R2: A request at an offset of 0x200 or above completes with up_err = 1 and up_rdata = 0, and it issues no register-side access.
- R3: A request to an unmapped slot completes with up_err = 1 and up_rdata = 0, and it issues no register-side access.
- R4: A request whose size equals the native width issues exactly one register-side access at the same address. The read data is returned masked to the access size.
- R5: A read narrower than its register issues one read of the whole aligned register and returns the addressed lane big-endian. A byte at offset 0 within the register is its most significant byte, and a halfword at offset 0 of a word register is its upper half.
- R6: A write narrower than its register issues exactly two accesses: a read of the aligned register, then a write of it with only the addressed lane replaced. All other bytes keep their values.
- R7: A request wider than its register issues size/width accesses at ascending addresses of the native size. The first access carries the most significant part of the write data, and read beats are merged with the first beat most significant.
- R8: While dn_valid is high and dn_ready is low, dn_valid stays high and dn_addr, dn_size and dn_we stay stable.
- R9: After reset, up_ready and dn_valid are low. Each request completes with up_ready high for exactly one cycle, and only after all of its register-side accesses have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Request present, held until up_ready |
| up_ready | output | 1 | One-cycle completion pulse |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word); address aligned to size |
| up_addr | input | ADDR_W | Byte offset of the request |
| up_wdata | input | 32 | Right-justified write data |
| up_rdata | output | 32 | Right-justified read data, zero for writes and errors |
| up_err | output | 1 | Out-of-range or unmapped request, valid with up_ready |
| dn_valid | output | 1 | Register-side access request |
| dn_ready | input | 1 | Register-side access accepted this cycle |
| dn_we | output | 1 | Register-side write |
| dn_size | output | 2 | Register-side size, always the native width |
| dn_addr | output | ADDR_W | Register-side byte address |
| dn_wdata | output | 32 | Register-side write data, right-justified |
| dn_rdata | input | 32 | Register-side read data, upper bits beyond the size ignored |

## Verification
**Beat counter and captured plan.** A beat counter or captured plan that goes wrong shows on the register port within the same request. It appears as a beat issued at the wrong address or with the wrong size, or as the completion pulse arriving after too few or too many beats.

**Accumulator and lane shift.** A wrong accumulator or lane shift does not show immediately on a write. It surfaces either in the returned read data of the same request or, for a read-modify-write, as a corrupted neighbouring byte that the next read of that register exposes. The bench therefore follows every merged write with a read of the whole register.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

   // native width code stored per 4-byte slot
   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_BYTE = 2'd1,
      SLOT_HALF = 2'd2,
      SLOT_WORD = 2'd3
   } slot_code_e;

   typedef enum logic [1:0] {
      MODE_PASS  = 2'd0,
      MODE_SPLIT = 2'd1,
      MODE_RMW   = 2'd2,
      MODE_FAIL  = 2'd3
   } plan_mode_e;

   // translation of one upstream request
   typedef struct packed {
      plan_mode_e mode;
      logic [1:0] beat_log;   // log2 bytes of each downstream beat
      logic [1:0] acc_log;    // log2 bytes of the upstream access
      logic [2:0] beats;      // number of downstream beats
      logic [4:0] shift;      // lane position in bits for narrow accesses
   } plan_t;

   // default mixed layout, scaled to the slot count
   function automatic slot_code_e mixed_code(input int idx, input int n);
      if (idx < n / 8)          return SLOT_BYTE;
      if (idx < (n * 5) / 16)   return SLOT_HALF;
      if (idx < n / 2)          return SLOT_WORD;
      if (idx < (n * 3) / 4)    return SLOT_BYTE;
      if (idx < (n * 7) / 8)    return SLOT_HALF;
      return SLOT_NONE;
   endfunction

endpackage

// File: rtl/rwa_slot_lut.sv
module rwa_slot_lut
   import rwa_pkg::*;
#(
   parameter int SLOT_BITS = 7,
   parameter int LAYOUT    = 0
) (
   input  logic [SLOT_BITS-1:0] slot,
   output slot_code_e           code
);
   localparam int NUM_SLOTS = 1 << SLOT_BITS;

   logic [1:0] tbl [NUM_SLOTS];

   generate
      if (LAYOUT == 0) begin : g_mixed
         for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
            assign tbl[i] = mixed_code(i, NUM_SLOTS);
         end
      end else begin : g_flat
         for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
            assign tbl[i] = SLOT_WORD;
         end
      end
   endgenerate

   assign code = slot_code_e'(tbl[slot]);
endmodule

// File: rtl/rwa_planner.sv
module rwa_planner
   import rwa_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [1:0]        acc_size,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              in_range,
   input  slot_code_e        code,
   output plan_t             plan,
   output logic [ADDR_W-1:0] base
);
   logic [1:0] nlog, wlog, c, lane;
   logic [2:0] nbytes, wbytes, diff;

   always_comb begin
      c      = code;
      nlog   = (acc_size > 2'd2) ? 2'd2 : acc_size;
      wlog   = (c == 2'd0) ? 2'd0 : c - 2'd1;
      nbytes = 3'd1 << nlog;
      wbytes = 3'd1 << wlog;
      lane   = acc_addr[1:0] & 2'(wbytes - 3'd1);
      diff   = wbytes - {1'b0, lane} - nbytes;

      plan.mode     = MODE_FAIL;
      plan.beat_log = wlog;
      plan.acc_log  = nlog;
      plan.beats    = 3'd0;
      plan.shift    = 5'd0;
      base          = acc_addr;

      if (!in_range || code == SLOT_NONE) begin
         plan.mode = MODE_FAIL;
      end else if (nlog == wlog) begin
         plan.mode  = MODE_PASS;
         plan.beats = 3'd1;
      end else if (nlog > wlog) begin
         plan.mode  = MODE_SPLIT;
         plan.beats = nbytes >> wlog;
      end else begin
         plan.mode  = MODE_RMW;
         plan.beats = acc_we ? 3'd2 : 3'd1;
         plan.shift = {diff[1:0], 3'b000};
         base       = acc_addr & ~{{(ADDR_W-3){1'b0}}, wbytes - 3'd1};
      end
   end
endmodule

// File: rtl/rwa_sequencer.sv
module rwa_sequencer
   import rwa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic              up_we,
   input  logic [DATA_W-1:0] up_wdata,
   input  plan_t             plan,
   input  logic [ADDR_W-1:0] base,
   output logic              up_ready,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              dn_valid,
   output logic              dn_we,
   output logic [1:0]        dn_size,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_ready,
   input  logic [DATA_W-1:0] dn_rdata
);
   typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_DONE} st_e;

   st_e               st_q;
   plan_t             plan_q;
   logic [ADDR_W-1:0] base_q;
   logic              we_q, err_q;
   logic [DATA_W-1:0] wdata_q, acc_q, rdata_q;
   logic [2:0]        cnt_q;

   logic [DATA_W-1:0] beat_mask, acc_mask, acc_next, final_rd, merged;
   logic [5:0]        beat_bits, slice_sh;
   logic              last_beat, beat_we;

   function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] lg);
      case (lg)
         2'd0:    return DATA_W'(32'h0000_00FF);
         2'd1:    return DATA_W'(32'h0000_FFFF);
         default: return '1;
      endcase
   endfunction

   always_comb begin
      beat_mask = lane_mask(plan_q.beat_log);
      acc_mask  = lane_mask(plan_q.acc_log);
      beat_bits = 6'd8 << plan_q.beat_log;
      last_beat = (cnt_q == plan_q.beats - 3'd1);
      beat_we   = (plan_q.mode == MODE_RMW) ? (cnt_q != 3'd0) : we_q;
      slice_sh  = 6'(32'(plan_q.beats - 3'd1 - cnt_q) * 32'(beat_bits));
      merged    = (acc_q & ~(acc_mask << plan_q.shift))
                | ((wdata_q & acc_mask) << plan_q.shift);
      acc_next  = (plan_q.mode == MODE_RMW) ? (dn_rdata & beat_mask)
                : ((acc_q << beat_bits) | (dn_rdata & beat_mask));
      final_rd  = (plan_q.mode == MODE_RMW) ? ((acc_next >> plan_q.shift) & acc_mask)
                : acc_next;

      dn_valid = (st_q == ST_BEAT);
      dn_we    = beat_we;
      dn_size  = plan_q.beat_log;
      dn_addr  = base_q + ((plan_q.mode == MODE_SPLIT)
                           ? (ADDR_W'(cnt_q) << plan_q.beat_log) : '0);
      case (plan_q.mode)
         MODE_SPLIT: dn_wdata = (wdata_q >> slice_sh) & beat_mask;
         MODE_RMW:   dn_wdata = merged & beat_mask;
         default:    dn_wdata = wdata_q & beat_mask;
      endcase

      up_ready = (st_q == ST_DONE);
      up_rdata = rdata_q;
      up_err   = err_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         plan_q  <= '0;
         base_q  <= '0;
         we_q    <= 1'b0;
         err_q   <= 1'b0;
         wdata_q <= '0;
         acc_q   <= '0;
         rdata_q <= '0;
         cnt_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (up_valid) begin
                  plan_q  <= plan;
                  base_q  <= base;
                  we_q    <= up_we;
                  wdata_q <= up_wdata;
                  cnt_q   <= '0;
                  acc_q   <= '0;
                  rdata_q <= '0;
                  err_q   <= (plan.mode == MODE_FAIL);
                  st_q    <= (plan.mode == MODE_FAIL) ? ST_DONE : ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (dn_ready) begin
                  if (!beat_we) acc_q <= acc_next;
                  cnt_q <= cnt_q + 3'd1;
                  if (last_beat) begin
                     rdata_q <= we_q ? '0 : final_rd;
                     st_q    <= ST_DONE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/regwidth_adapter.sv
module regwidth_adapter
   import rwa_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SLOT_BITS = 7,
   parameter int LAYOUT    = 0,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_we,
   input  logic [1:0]        up_size,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_we,
   output logic [1:0]        dn_size,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam int WIN_BITS = SLOT_BITS + 2;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("regwidth_adapter: DATA_W must be 32");
      end
      if (SLOT_BITS < 4) begin : g_bad_slots
         $error("regwidth_adapter: SLOT_BITS must be at least 4");
      end
      if (ADDR_W < WIN_BITS) begin : g_bad_addr
         $error("regwidth_adapter: ADDR_W too small for the slot window");
      end
   endgenerate

   logic              in_range;
   slot_code_e        lut_code;
   plan_t             plan;
   logic [ADDR_W-1:0] base;

   generate
      if (ADDR_W > WIN_BITS) begin : g_range
         assign in_range = (up_addr[ADDR_W-1:WIN_BITS] == '0);
      end else begin : g_full
         assign in_range = 1'b1;
      end
   endgenerate

   rwa_slot_lut #(
      .SLOT_BITS(SLOT_BITS),
      .LAYOUT   (LAYOUT)
   ) u_lut (
      .slot(up_addr[WIN_BITS-1:2]),
      .code(lut_code)
   );

   rwa_planner #(
      .ADDR_W(ADDR_W)
   ) u_planner (
      .acc_size(up_size),
      .acc_we  (up_we),
      .acc_addr(up_addr),
      .in_range(in_range),
      .code    (lut_code),
      .plan    (plan),
      .base    (base)
   );

   rwa_sequencer #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_valid(up_valid),
      .up_we   (up_we),
      .up_wdata(up_wdata),
      .plan    (plan),
      .base    (base),
      .up_ready(up_ready),
      .up_rdata(up_rdata),
      .up_err  (up_err),
      .dn_valid(dn_valid),
      .dn_we   (dn_we),
      .dn_size (dn_size),
      .dn_addr (dn_addr),
      .dn_wdata(dn_wdata),
      .dn_ready(dn_ready),
      .dn_rdata(dn_rdata)
   );
endmodule

// File: rtl/rwa_checker.sv
module rwa_checker #(
   parameter int ADDR_W    = 16,
   parameter int SLOT_BITS = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_ready,
   input logic              up_err,
   input logic [ADDR_W-1:0] up_addr,
   input logic [31:0]       up_rdata,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic              dn_we,
   input logic [1:0]        dn_size,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [1:0]        slot_code
);
   localparam int WIN_BITS = SLOT_BITS + 2;

   logic out_of_range;
   assign out_of_range = ((up_addr >> WIN_BITS) != '0);

   // R8: register-side request is held until accepted
   a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_size) && $stable(dn_we));

   // R2: nothing forwarded above the window
   a_r2_no_forward_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && out_of_range |-> !dn_valid);

   // R3: nothing forwarded to an unmapped slot
   a_r3_no_forward_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && slot_code == 2'd0 |-> !dn_valid);

   // R1: every beat uses the slot's native size
   a_r1_native_size: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_size == slot_code - 2'd1);

   // R1: every beat stays in the requested slot
   a_r1_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_addr[ADDR_W-1:2] == up_addr[ADDR_W-1:2]);

   // R9: completion lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |=> !up_ready);

   // R2, R3: an error completion returns zero data
   a_r3_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready && up_err |-> up_rdata == 32'd0);
endmodule

bind regwidth_adapter rwa_checker #(
   .ADDR_W   (ADDR_W),
   .SLOT_BITS(SLOT_BITS)
) u_rwa_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .up_valid (up_valid),
   .up_ready (up_ready),
   .up_err   (up_err),
   .up_addr  (up_addr),
   .up_rdata (up_rdata),
   .dn_valid (dn_valid),
   .dn_ready (dn_ready),
   .dn_we    (dn_we),
   .dn_size  (dn_size),
   .dn_addr  (dn_addr),
   .slot_code(lut_code)
);

// File: tb/regwidth_adapter_bench.sv
module regwidth_adapter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;

   typedef struct packed {
      logic [31:0] rdata;
      logic        err;
      logic [7:0]  beats;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              up_valid = 1'b0, up_we = 1'b0;
   logic [1:0]        up_size = 2'd0;
   logic [ADDR_W-1:0] up_addr = '0;
   logic [31:0]       up_wdata = '0;
   logic              up_ready, up_err;
   logic [31:0]       up_rdata;
   logic              dn_valid, dn_we;
   logic              dn_ready = 1'b0;
   logic [1:0]        dn_size;
   logic [ADDR_W-1:0] dn_addr;
   logic [31:0]       dn_wdata;
   logic [31:0]       dn_rdata = '0;

   int   checks = 0, errors = 0;
   bit   finished = 1'b0;
   exp_t exp_q[$];
   string name_q[$];
   logic [7:0] dev_mem [512];
   logic [7:0] ref_mem [512];
   int   beat_cnt = 0, wait_cnt = 0, delay = 0;
   logic [ADDR_W-1:0] held_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regwidth_adapter u_regwidth_adapter (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_we(up_we), .up_size(up_size),
      .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata), .up_err(up_err),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_we(dn_we), .dn_size(dn_size),
      .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
   );

   // native width in bytes from the R1 layout, 0 = unmapped or outside
   function automatic int ref_width(input int a);
      int s;
      if (a >= 512) return 0;
      s = a / 4;
      if (s < 16)  return 1;
      if (s < 40)  return 2;
      if (s < 64)  return 4;
      if (s < 96)  return 1;
      if (s < 112) return 2;
      return 0;
   endfunction

   function automatic logic [31:0] get_ref(input int a, input int n);
      logic [31:0] r = '0;
      for (int k = 0; k < n; k++) r = (r << 8) | 32'(ref_mem[a+k]);
      return r;
   endfunction

   function automatic logic [31:0] get_dev(input int a, input int n);
      logic [31:0] r = '0;
      for (int k = 0; k < n; k++) r = (r << 8) | 32'(dev_mem[a+k]);
      return r;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   // register-file responder and completion monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         dn_ready = 1'b0;
      end else begin
         if (dn_valid) begin
            int w, exp_sz;
            if (wait_cnt > 0)
               check(dn_addr == held_addr, "R8", "held address", 32'(dn_addr), 32'(held_addr));
            held_addr = dn_addr;
            if (wait_cnt >= delay) begin
               w = 1 << dn_size;
               exp_sz = (ref_width(int'(dn_addr)) == 4) ? 2 : (ref_width(int'(dn_addr)) == 2) ? 1 : 0;
               check(int'(dn_size) == exp_sz, "R1", "native size", 32'(dn_size), 32'(exp_sz));
               dn_rdata = get_dev(int'(dn_addr), w);
               if (w == 1) dn_rdata = dn_rdata | 32'hC3C3_C300;
               if (w == 2) dn_rdata = dn_rdata | 32'hC3C3_0000;
               if (dn_we)
                  for (int k = 0; k < w; k++)
                     dev_mem[int'(dn_addr)+k] = 8'(dn_wdata >> (8*(w-1-k)));
               dn_ready = 1'b1;
               beat_cnt++;
               wait_cnt = 0;
               delay = (delay + 1) % 3;
            end else begin
               dn_ready = 1'b0;
               wait_cnt++;
            end
         end else begin
            dn_ready = 1'b0;
            wait_cnt = 0;
         end

         if (up_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected completion", 32'd1, 32'd0);
            end else begin
               exp_t e;
               string rq;
               e  = exp_q.pop_front();
               rq = name_q.pop_front();
               check(up_rdata == e.rdata, rq, "read data", up_rdata, e.rdata);
               check(up_err == e.err, rq, "error flag", 32'(up_err), 32'(e.err));
               check(beat_cnt == int'(e.beats), {rq, "/R9"}, "register beats",
                     32'(beat_cnt), 32'(e.beats));
            end
            beat_cnt = 0;
         end
      end
   end

   task automatic do_acc(input bit we, input int n, input int a,
                         input logic [31:0] wd, input string rq);
      exp_t e;
      int   w;
      w = ref_width(a);
      e.err   = (w == 0);
      e.rdata = '0;
      e.beats = '0;
      if (w != 0) begin
         e.beats = 8'((n == w) ? 1 : (n > w) ? n / w : (we ? 2 : 1));
         if (!we) e.rdata = get_ref(a, n);
         else for (int k = 0; k < n; k++) ref_mem[a+k] = 8'(wd >> (8*(n-1-k)));
      end
      exp_q.push_back(e);
      name_q.push_back(rq);
      @(negedge clk);
      up_valid = 1'b1;
      up_we    = we;
      up_size  = (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
      up_addr  = ADDR_W'(a);
      up_wdata = wd;
      @(negedge clk);
      while (!up_ready) @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual hung expected complete");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) begin
         dev_mem[i] = 8'(i * 37 + 11);
         ref_mem[i] = 8'(i * 37 + 11);
      end
      repeat (3) @(negedge clk);
      // R9 reset state
      check(up_ready == 1'b0, "R9", "reset up_ready", 32'(up_ready), 32'd0);
      check(dn_valid == 1'b0, "R9", "reset dn_valid", 32'(dn_valid), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 matching sizes
      do_acc(0, 1, 'h001, 32'h0, "R4");
      do_acc(0, 2, 'h040, 32'h0, "R4");
      do_acc(0, 4, 'h0A0, 32'h0, "R4");
      do_acc(1, 4, 'h0A4, 32'h1234_5678, "R4");
      do_acc(0, 4, 'h0A4, 32'h0, "R4");
      do_acc(1, 1, 'h102, 32'hFFFF_FF5A, "R4");
      do_acc(0, 1, 'h102, 32'h0, "R4");

      // R5 narrow reads
      do_acc(0, 1, 'h040, 32'h0, "R5");
      do_acc(0, 1, 'h041, 32'h0, "R5");
      do_acc(0, 1, 'h0A8, 32'h0, "R5");
      do_acc(0, 1, 'h0AB, 32'h0, "R5");
      do_acc(0, 2, 'h0A8, 32'h0, "R5");
      do_acc(0, 2, 'h0AA, 32'h0, "R5");

      // R6 narrow writes, then whole-register reads
      do_acc(1, 1, 'h0B2, 32'h0000_00E7, "R6");
      do_acc(0, 4, 'h0B0, 32'h0, "R6");
      do_acc(1, 2, 'h0B4, 32'h0000_BEEF, "R6");
      do_acc(0, 4, 'h0B4, 32'h0, "R6");
      do_acc(1, 1, 'h045, 32'h0000_0011, "R6");
      do_acc(0, 2, 'h044, 32'h0, "R6");
      do_acc(1, 1, 'h0C0, 32'h0000_0099, "R6");
      do_acc(0, 4, 'h0C0, 32'h0, "R6");

      // R7 wide accesses to narrow registers
      do_acc(0, 4, 'h008, 32'h0, "R7");
      do_acc(0, 2, 'h00E, 32'h0, "R7");
      do_acc(0, 4, 'h048, 32'h0, "R7");
      do_acc(1, 4, 'h010, 32'hA1B2_C3D4, "R7");
      do_acc(0, 1, 'h010, 32'h0, "R7");
      do_acc(0, 1, 'h013, 32'h0, "R7");
      do_acc(1, 4, 'h050, 32'h0102_0304, "R7");
      do_acc(0, 2, 'h052, 32'h0, "R7");
      do_acc(1, 2, 'h14A, 32'h0000_7E81, "R7");
      do_acc(0, 2, 'h14A, 32'h0, "R7");
      do_acc(0, 4, 'h1BC, 32'h0, "R7");

      // R2 outside the window, alias of a byte register left untouched
      do_acc(0, 4, 'h200, 32'h0, "R2");
      do_acc(1, 4, 'h204, 32'hDEAD_BEEF, "R2");
      do_acc(0, 4, 'h004, 32'h0, "R2");
      do_acc(1, 1, 'h3FF, 32'h0000_0077, "R2");

      // R3 unmapped slots
      do_acc(0, 4, 'h1C0, 32'h0, "R3");
      do_acc(1, 2, 'h1C4, 32'h0000_5555, "R3");
      do_acc(0, 1, 'h1FF, 32'h0, "R3");

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R9", "pending completions", 32'(exp_q.size()), 32'd0);
      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end
endmodule